// File: doc/BRIEF.md
# Cache Event Counter Unit

This block watches a shared cache and counts how often selected events happen. It has sixteen programmable event counters and one free-running cycle counter, all 64 bits wide. They sit behind a small 64-bit register port that has a write enable, a read strobe and one cycle of read latency.

Each event counter has a 32-bit select register. Software writes an opaque event code into it, and the counter then advances on every pulse of the matching cache event line. A single global enable bit starts and freezes all counting at once. Every counter can be preloaded with a start value. When a counter wraps from all ones to zero, its overflow flag is set. Software clears these flags by writing ones. An interrupt output is raised while any flagged counter also has its interrupt enable bit set.

Top module: `cache_perf_mon`

## Requirements
- R1: After reset, all of the following are zero: every counter, every select register, the enable bit, the overflow flags and the interrupt enables. The interrupt output is low and the read data is zero.
- R2: The register map uses byte addresses on 8-byte words:
  - 0x040 holds the enable flag in bit 0.
  - 0x048 holds the overflow flags.
  - 0x050 holds the interrupt enables.
  - 0x058 holds the cycle counter.
  - Event counter n has its select register at 0x060+8n and its count at 0x160+8n, for n = 0..15.
- R3: While the enable bit is 1, the cycle counter adds one on every clock edge, without any select programming.
- R4: An event counter adds one on each clock edge where the enable bit is 1 and the pulse line for its selected code is high. The code-to-line mapping is:
  - line 0 = 0x04000701
  - line 1 = 0x03000001
  - line 2 = 0x0003e001
  - line 3 = 0x00901202
  - line 4 = 0x04008002
  - line 5 = 0x006c0002
  - line 6 = 0x03000002
  - line 7 = 0x00000403
- R5: A counter whose select register holds a code outside that set never counts.
- R6: Any counter can be written to preload it. A write on the same edge as an increment takes the written value.
- R7: While the enable bit is 0, every counter, including the cycle counter, keeps its value.
- R8: A counter that wraps from all ones to zero sets its overflow flag and keeps counting from zero. Event counter n uses flag bit n, and the cycle counter uses bit 63.
- R9: Writing the flag word clears only the bits written as 1, and bits written as 0 are unchanged. If a wrap and a clear hit the same bit on the same edge, the bit ends up set.
- R10: The interrupt output is high exactly when some flag bit is set while the same interrupt-enable bit is set.
- R11: A read returns its data on the cycle after the strobe. The following all read as zero:
  - unmapped or misaligned addresses
  - unused bits of the flag, enable and control words
  - the upper 32 bits of a select register

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 64 | Read data, valid the cycle after reg_re |
| evt_pulse | input | 8 | Single-cycle cache event pulse lines |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest situations to reach are a 64-bit wrap and a flag clear that lands on the same edge as a wrap. Counting up from zero could never get there, so the stimulus preloads counters to just below all ones. It then issues the clearing write in the same cycle as the final event pulse. A write to a counter in the same cycle as a matching pulse checks that the write takes priority. A cycle-accurate reference model in the bench tracks every write, pulse and enable change, so the reads land on exact expected values.

// File: rtl/cpmu_pkg.sv
package cpmu_pkg;
    localparam int unsigned CODE_CNT = 8;
    localparam int unsigned SEL_W    = 32;

    // cache event codes, index = pulse line number
    localparam logic [SEL_W-1:0] EVT_CODES [CODE_CNT] = '{
        32'h04000701, 32'h03000001, 32'h0003e001, 32'h00901202,
        32'h04008002, 32'h006c0002, 32'h03000002, 32'h00000403
    };

    localparam int unsigned OFS_CTRL = 'h040;
    localparam int unsigned OFS_FLAG = 'h048;
    localparam int unsigned OFS_IEN  = 'h050;
    localparam int unsigned OFS_CYC  = 'h058;
    localparam int unsigned OFS_SEL  = 'h060;
    localparam int unsigned OFS_CNT  = 'h160;
    localparam int unsigned STRIDE   = 8;
endpackage

// File: rtl/cpmu_evt_match.sv
module cpmu_evt_match
    import cpmu_pkg::*;
(
    input  logic [SEL_W-1:0]    sel,
    input  logic [CODE_CNT-1:0] evt,
    output logic                hit
);
    logic [CODE_CNT-1:0] line_on;

    for (genvar g = 0; g < CODE_CNT; g++) begin : g_code
        assign line_on[g] = (sel == EVT_CODES[g]);
    end

    assign hit = |(line_on & evt);
endmodule

// File: rtl/cpmu_counter.sv
module cpmu_counter #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0] val;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.val = load_val;
        end else if (inc) begin
            s_d.val = s_q.val + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign val  = s_q.val;
    assign wrap = inc & ~load & (&s_q.val);

    // R6: a preload write takes priority over any increment
    a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> val == $past(load_val));

    // R7: no load and no increment keeps the value
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !inc) |=> $stable(val));

    // R8: the increment from all ones lands on zero
    a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && (&val)) |=> val == '0);
endmodule

// File: rtl/cache_perf_mon.sv
module cache_perf_mon
    import cpmu_pkg::*;
#(
    parameter int unsigned NUM_EVT = 16,
    parameter int unsigned CNT_W   = 64,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                reg_re,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [CODE_CNT-1:0] evt_pulse,
    output logic                irq
);
    localparam int unsigned TRK     = NUM_EVT + 1;
    localparam int unsigned CYC_IDX = NUM_EVT;

    typedef struct packed {
        logic                            en;
        logic [TRK-1:0]                  flag;
        logic [TRK-1:0]                  ien;
        logic [NUM_EVT-1:0][SEL_W-1:0]   sel;
        logic [DATA_W-1:0]               rdata;
    } regs_t;

    regs_t r_d, r_q;

    // word <-> tracked-bit conversion: event n at bit n, cycle at top bit
    function automatic logic [TRK-1:0] word_to_trk(input logic [DATA_W-1:0] w);
        logic [TRK-1:0] t;
        t          = '0;
        t[NUM_EVT-1:0] = w[NUM_EVT-1:0];
        t[CYC_IDX] = w[DATA_W-1];
        return t;
    endfunction

    function automatic logic [DATA_W-1:0] trk_to_word(input logic [TRK-1:0] t);
        logic [DATA_W-1:0] w;
        w               = '0;
        w[NUM_EVT-1:0]  = t[NUM_EVT-1:0];
        w[DATA_W-1]     = t[CYC_IDX];
        return w;
    endfunction

    // ---------------- decode ----------------
    logic               is_ctrl, is_flag, is_ien, is_cyc;
    logic [NUM_EVT-1:0] sel_match, cnt_match;
    logic               any_map;

    assign is_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
    assign is_flag = (reg_addr == ADDR_W'(OFS_FLAG));
    assign is_ien  = (reg_addr == ADDR_W'(OFS_IEN));
    assign is_cyc  = (reg_addr == ADDR_W'(OFS_CYC));

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_dec
        assign sel_match[g] = (reg_addr == ADDR_W'(OFS_SEL + STRIDE * g));
        assign cnt_match[g] = (reg_addr == ADDR_W'(OFS_CNT + STRIDE * g));
    end

    assign any_map = is_ctrl | is_flag | is_ien | is_cyc | (|sel_match) | (|cnt_match);

    // ---------------- counters ----------------
    logic [NUM_EVT-1:0][CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0]              cyc_val;
    logic [NUM_EVT-1:0]            evt_hit;
    logic [TRK-1:0]                wrap_all;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        cpmu_evt_match u_match (
            .sel (r_q.sel[g]),
            .evt (evt_pulse),
            .hit (evt_hit[g])
        );

        cpmu_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (reg_we & cnt_match[g]),
            .load_val (reg_wdata[CNT_W-1:0]),
            .inc      (r_q.en & evt_hit[g]),
            .val      (cnt_val[g]),
            .wrap     (wrap_all[g])
        );
    end

    cpmu_counter #(.W(CNT_W)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reg_we & is_cyc),
        .load_val (reg_wdata[CNT_W-1:0]),
        .inc      (r_q.en),
        .val      (cyc_val),
        .wrap     (wrap_all[CYC_IDX])
    );

    // ---------------- read mux ----------------
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (is_ctrl) rd_mux[0] = r_q.en;
        if (is_flag) rd_mux = trk_to_word(r_q.flag);
        if (is_ien)  rd_mux = trk_to_word(r_q.ien);
        if (is_cyc)  rd_mux = DATA_W'(cyc_val);
        for (int i = 0; i < NUM_EVT; i++) begin
            if (sel_match[i]) rd_mux = DATA_W'(r_q.sel[i]);
            if (cnt_match[i]) rd_mux = DATA_W'(cnt_val[i]);
        end
    end

    // ---------------- next state ----------------
    logic [TRK-1:0] clr;

    assign clr = (reg_we && is_flag) ? word_to_trk(reg_wdata) : '0;

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            if (is_ctrl) r_d.en  = reg_wdata[0];
            if (is_ien)  r_d.ien = word_to_trk(reg_wdata);
            for (int i = 0; i < NUM_EVT; i++) begin
                if (sel_match[i]) r_d.sel[i] = reg_wdata[SEL_W-1:0];
            end
        end
        // a wrap on the same edge beats a clear
        r_d.flag = (r_q.flag & ~clr) | wrap_all;
        if (reg_re) r_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign reg_rdata = r_q.rdata;
    assign irq       = |(r_q.flag & r_q.ien);

    // ---------------- assertions ----------------
    // R3: enabled cycle counter steps by one unless software writes it
    a_r3_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en && !(reg_we && is_cyc)) |=> cyc_val == $past(cyc_val) + CNT_W'(1));

    // R11: unmapped reads return zero on the next cycle
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && !any_map) |=> reg_rdata == '0);

    for (genvar g = 0; g < TRK; g++) begin : g_flag_chk
        // R8: a wrap leaves its flag set
        a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            wrap_all[g] |=> r_q.flag[g]);
        // R9: a clear without a concurrent wrap drops the flag
        a_r9_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !wrap_all[g]) |=> !r_q.flag[g]);
    end
endmodule

// File: tb/cache_perf_mon_tb.sv
`timescale 1ns/1ps
module cache_perf_mon_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic        reg_re = 1'b0;
    logic [63:0] reg_rdata;
    logic [7:0]  evt_pulse = '0;
    logic        irq;

    always #5 clk = ~clk;

    cache_perf_mon u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .evt_pulse(evt_pulse), .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    string cur_tag = "";

    // ---------------- reference model ----------------
    localparam logic [63:0] MAP_MASK = 64'h8000_0000_0000_FFFF;
    logic [63:0] m_cnt [16];
    logic [31:0] m_sel [16];
    logic [63:0] m_cyc, m_flag, m_ien;
    logic        m_en;

    function automatic int line_of(input logic [31:0] c);
        case (c)
            32'h04000701: return 0;
            32'h03000001: return 1;
            32'h0003e001: return 2;
            32'h00901202: return 3;
            32'h04008002: return 4;
            32'h006c0002: return 5;
            32'h03000002: return 6;
            32'h00000403: return 7;
            default:      return -1;
        endcase
    endfunction

    function automatic logic [63:0] rd_exp(input logic [11:0] a);
        if (a == 12'h040) return {63'd0, m_en};
        if (a == 12'h048) return m_flag;
        if (a == 12'h050) return m_ien;
        if (a == 12'h058) return m_cyc;
        for (int i = 0; i < 16; i++) begin
            if (a == 12'(12'h060 + 8 * i)) return {32'd0, m_sel[i]};
            if (a == 12'(12'h160 + 8 * i)) return m_cnt[i];
        end
        return 64'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                m_cnt[i] = '0;
                m_sel[i] = '0;
            end
            m_cyc = '0; m_flag = '0; m_ien = '0; m_en = 1'b0;
        end else begin
            logic        en_now;
            logic [63:0] set_w, clr_w;
            int          ln;
            en_now = m_en;
            set_w  = '0;
            clr_w  = '0;
            if (reg_re) sb.push_back('{rd_exp(reg_addr), cur_tag});
            for (int i = 0; i < 16; i++) begin
                ln = line_of(m_sel[i]);
                if (reg_we && reg_addr == 12'(12'h160 + 8 * i)) begin
                    m_cnt[i] = reg_wdata;
                end else if (en_now && ln >= 0 && evt_pulse[ln]) begin
                    if (m_cnt[i] == '1) set_w[i] = 1'b1;
                    m_cnt[i] = m_cnt[i] + 64'd1;
                end
            end
            if (reg_we && reg_addr == 12'h058) begin
                m_cyc = reg_wdata;
            end else if (en_now) begin
                if (m_cyc == '1) set_w[63] = 1'b1;
                m_cyc = m_cyc + 64'd1;
            end
            if (reg_we) begin
                if (reg_addr == 12'h040) m_en = reg_wdata[0];
                if (reg_addr == 12'h050) m_ien = reg_wdata & MAP_MASK;
                if (reg_addr == 12'h048) clr_w = reg_wdata & MAP_MASK;
                for (int i = 0; i < 16; i++)
                    if (reg_addr == 12'(12'h060 + 8 * i)) m_sel[i] = reg_wdata[31:0];
            end
            m_flag = (m_flag & ~clr_w) | set_w;
        end
    end

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_cmp++;
            if (reg_rdata !== it.exp) begin
                n_bad++;
                $display("FAIL %s: read got %h expected %h", it.tag, reg_rdata, it.exp);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic cyc1(input logic we, input logic [11:0] a, input logic [63:0] d,
                        input logic re, input logic [7:0] ev);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; reg_re = re; evt_pulse = ev;
        @(posedge clk);
        #1;
        reg_we = 1'b0; reg_re = 1'b0; evt_pulse = '0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        cyc1(1'b1, a, d, 1'b0, 8'h00);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        cur_tag = tag;
        cyc1(1'b0, a, 64'd0, 1'b1, 8'h00);
    endtask

    task automatic pulse(input logic [7:0] ev);
        cyc1(1'b0, 12'h000, 64'd0, 1'b0, ev);
    endtask

    task automatic chk_irq(input string tag);
        logic e;
        @(negedge clk);
        e = |(m_flag & m_ien);
        n_cmp++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, e);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    localparam logic [31:0] CODES [8] = '{32'h04000701, 32'h03000001, 32'h0003e001,
        32'h00901202, 32'h04008002, 32'h006c0002, 32'h03000002, 32'h00000403};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(12'h040, "R1"); rd(12'h048, "R1"); rd(12'h050, "R1");
        rd(12'h058, "R1"); rd(12'h160, "R1"); rd(12'h060, "R1");
        chk_irq("R1");

        // R11 unmapped, misaligned, unused bits
        rd(12'h000, "R11"); rd(12'h044, "R11"); rd(12'h1e0, "R11"); rd(12'h038, "R11");
        wr(12'h050, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h050, "R11");
        wr(12'h050, 64'd0);
        wr(12'h040, 64'hFFFF_FFFF_FFFF_FFFE);
        rd(12'h040, "R11");
        wr(12'h068, 64'hDEAD_BEEF_0000_0000);
        rd(12'h068, "R11");

        // R2 / R4 / R5 programming
        for (int i = 0; i < 8; i++) wr(12'(12'h060 + 8 * i), {32'd0, CODES[i]});
        wr(12'h0A0, {32'd0, CODES[0]});
        wr(12'h0A8, 64'h0000_0000_1234_5678);
        wr(12'h0B0, 64'h0000_0000_0400_0700);
        rd(12'h078, "R2");
        wr(12'h040, 64'd1);
        pulse(8'h01); pulse(8'hFF); pulse(8'hA5); pulse(8'h10); pulse(8'h00); pulse(8'h81);
        for (int i = 0; i < 9; i++) rd(12'(12'h160 + 8 * i), "R4");
        rd(12'h1B0, "R5"); rd(12'h1A8, "R5");
        rd(12'h058, "R3"); rd(12'h058, "R3");

        // R7 freeze
        wr(12'h040, 64'd0);
        pulse(8'hFF); pulse(8'hFF);
        rd(12'h058, "R7"); rd(12'h058, "R7");
        rd(12'h160, "R7"); rd(12'h178, "R7");

        // R6 preload, write wins over increment
        wr(12'h040, 64'd1);
        cyc1(1'b1, 12'h168, 64'h1000, 1'b0, 8'h02);
        rd(12'h168, "R6");
        wr(12'h058, 64'h500);
        rd(12'h058, "R6");

        // R8 wrap of event counter 3 and cycle counter
        wr(12'h178, 64'hFFFF_FFFF_FFFF_FFFE);
        pulse(8'h08); pulse(8'h08); pulse(8'h08);
        rd(12'h178, "R8"); rd(12'h048, "R8");
        wr(12'h058, 64'hFFFF_FFFF_FFFF_FFFD);
        pulse(8'h00); pulse(8'h00); pulse(8'h00);
        rd(12'h048, "R8"); rd(12'h058, "R8");

        // R10 interrupt masking
        chk_irq("R10");
        wr(12'h050, 64'h8);
        chk_irq("R10");
        wr(12'h050, 64'h8000_0000_0000_0000);
        chk_irq("R10");
        wr(12'h048, 64'h8000_0000_0000_0000);
        chk_irq("R10");

        // R9 write-one-to-clear
        wr(12'h048, 64'd0);
        rd(12'h048, "R9");
        wr(12'h048, 64'h8);
        rd(12'h048, "R9");
        wr(12'h188, 64'hFFFF_FFFF_FFFF_FFFF);
        pulse(8'h20);
        rd(12'h048, "R9");
        wr(12'h188, 64'hFFFF_FFFF_FFFF_FFFF);
        cyc1(1'b1, 12'h048, 64'h20, 1'b0, 8'h20);
        rd(12'h048, "R9");
        rd(12'h188, "R9");

        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            summary();
            $finish;
        end
    end
endmodule